// File: doc/BRIEF.md
# Two-Wide In-Order Issue Pairing Logic

This block sits between the instruction queue and the execution pipelines of an in-order, two-wide core. Each cycle it looks at the two oldest decoded instructions (slot A is the older, slot B the younger) and at a per-register readiness scoreboard. From these it decides whether nothing, only the older instruction, or both instructions issue. It also tells the queue how many entries to retire. The older instruction always goes to pipe 0 and a paired younger one to pipe 1.

Pairing is limited by the execution resources. There is one load/store unit, which either pipe can reach. There is one branch port, also reachable from either pipe. The multiplier hangs off pipe 0 only. Two instructions with the same destination cannot issue together. A younger instruction that reads the older one's result cannot issue with it. An instruction whose sources are still pending waits, and when the older one waits, nothing issues. A multi-cycle instruction repeats in pipe 0 and may only share its final iteration with a partner. The queue owns the remaining-iteration count: it decrements that count whenever the block reports a consume of zero for an issued non-final iteration.

The scoreboard keeps a small countdown per register. When a register is issued as a destination, it is marked pending for a number of cycles that depends on the producing unit.

Top module: `pair_issue`

## Requirements
- R1: After reset every register is ready. An older ALU instruction whose three sources are all in use issues at once. With slot A invalid, both issue enables are 0 and consume is 0.
- R2: Pipe 1 issues only when pipe 0 issues in the same cycle. The older slot always occupies pipe 0.
- R3: At most one load/store instruction (unit code 1) issues per cycle. A load/store in either slot may pair with a non-load/store partner.
- R4: A multiply (unit code 2) in slot B never pairs. A multiply in slot A pairs with a suitable younger instruction.
- R5: At most one branch issues per cycle. A branch is unit code 3, or any instruction that writes register 15.
- R6: Two instructions whose enabled destinations are equal do not issue together.
- R7: An instruction whose enabled source is pending does not issue. While slot A is blocked, slot B does not issue either.
- R8: Slot B does not pair when one of its enabled sources equals slot A's enabled destination.
- R9: An issued destination stays pending for 1 cycle after an ALU or branch producer (code 0 or 3), for 2 cycles after a load/store, and for 3 cycles after a multiply. A dependent instruction presented in the following cycle therefore stalls exactly that many cycles.
- R10: A multi-cycle instruction in slot A with a nonzero remaining count issues alone with consume 0. With a remaining count of 0 it may pair. A multi-cycle instruction in slot B never pairs.
- R11: Consume is 2 when both pipes issue, 1 when only pipe 0 issues a single-cycle or final-iteration instruction, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Older slot holds an instruction |
| a_unit | input | 2 | Older unit code: 0 ALU, 1 load/store, 2 multiply, 3 branch |
| a_dst | input | RW | Older destination register |
| a_wr | input | 1 | Older destination write enable |
| a_src | input | NSRC*RW | Older source registers |
| a_use | input | NSRC | Older source enables |
| a_multi | input | 1 | Older is multi-cycle |
| a_rest | input | ITW | Older iterations still to come after this one |
| b_valid | input | 1 | Younger slot holds an instruction |
| b_unit | input | 2 | Younger unit code |
| b_dst | input | RW | Younger destination register |
| b_wr | input | 1 | Younger destination write enable |
| b_src | input | NSRC*RW | Younger source registers |
| b_use | input | NSRC | Younger source enables |
| b_multi | input | 1 | Younger is multi-cycle |
| pipe0 | output | 1 | Older instruction issues in pipe 0 |
| pipe1 | output | 1 | Younger instruction issues in pipe 1 |
| consume | output | 2 | Queue entries retired this cycle |

## Verification
The bench builds the block with its defaults: 16 registers (so register 15 serves as the program-counter destination), three sources per slot, a 3-bit iteration count, and latencies of 1, 2 and 3 cycles. With these latencies every stall length is short enough to measure cycle by cycle with a dependent instruction held in slot A. The 3-bit count allows a four-transfer multi-cycle load to walk through three non-final iterations before its final, paired one.

// File: rtl/pi_pkg.sv
package pi_pkg;
    typedef enum logic [1:0] {
        U_ALU = 2'd0,
        U_LS  = 2'd1,
        U_MUL = 2'd2,
        U_BR  = 2'd3
    } unit_e;

    function automatic int lat_of(input logic [1:0] unit, input int l_alu,
                                  input int l_ls, input int l_mul);
        case (unit_e'(unit))
            U_LS:    return l_ls;
            U_MUL:   return l_mul;
            default: return l_alu;
        endcase
    endfunction
endpackage

// File: rtl/pi_src_check.sv
module pi_src_check #(
    parameter int NREG = 16,
    parameter int NSRC = 3,
    parameter int RW   = $clog2(NREG)
) (
    input  logic [NREG-1:0]          ready,
    input  logic [NSRC-1:0][RW-1:0]  src,
    input  logic [NSRC-1:0]          use_en,
    output logic                     ok
);
    logic [NSRC-1:0] blk;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign blk[i] = use_en[i] && !ready[src[i]];
    end

    assign ok = ~|blk;
endmodule

// File: rtl/pi_scoreboard.sv
module pi_scoreboard
    import pi_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int RW    = $clog2(NREG),
    parameter int L_ALU = 1,
    parameter int L_LS  = 2,
    parameter int L_MUL = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set0,
    input  logic [RW-1:0]   dst0,
    input  logic [1:0]      unit0,
    input  logic            set1,
    input  logic [RW-1:0]   dst1,
    input  logic [1:0]      unit1,
    output logic [NREG-1:0] ready
);
    localparam int LMAX = (L_ALU > L_LS) ? ((L_ALU > L_MUL) ? L_ALU : L_MUL)
                                         : ((L_LS > L_MUL) ? L_LS : L_MUL);
    localparam int CW = $clog2(LMAX + 1);

    typedef struct packed {
        logic [NREG-1:0][CW-1:0] cnt;
    } sb_t;

    sb_t sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        for (int r = 0; r < NREG; r++) begin
            if (sb_q.cnt[r] != '0) sb_d.cnt[r] = sb_q.cnt[r] - 1'b1;
        end
        if (set0) sb_d.cnt[dst0] = CW'(lat_of(unit0, L_ALU, L_LS, L_MUL));
        if (set1) sb_d.cnt[dst1] = CW'(lat_of(unit1, L_ALU, L_LS, L_MUL));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    for (genvar r = 0; r < NREG; r++) begin : g_rdy
        assign ready[r] = (sb_q.cnt[r] == '0);
    end
endmodule

// File: rtl/pi_pair_rules.sv
module pi_pair_rules
    import pi_pkg::*;
#(
    parameter int NSRC   = 3,
    parameter int RW     = 4,
    parameter int ITW    = 3,
    parameter int PC_REG = 15
) (
    input  logic                    a_valid,
    input  logic                    a_ok,
    input  logic [1:0]              a_unit,
    input  logic [RW-1:0]           a_dst,
    input  logic                    a_wr,
    input  logic                    a_multi,
    input  logic [ITW-1:0]          a_rest,
    input  logic                    b_valid,
    input  logic                    b_ok,
    input  logic [1:0]              b_unit,
    input  logic [RW-1:0]           b_dst,
    input  logic                    b_wr,
    input  logic [NSRC-1:0][RW-1:0] b_src,
    input  logic [NSRC-1:0]         b_use,
    input  logic                    b_multi,
    output logic                    pipe0,
    output logic                    pipe1,
    output logic [1:0]              consume
);
    logic a_last, a_br, b_br, raw, clash;

    always_comb begin
        a_last = !a_multi || (a_rest == '0);
        a_br   = (unit_e'(a_unit) == U_BR) || (a_wr && a_dst == RW'(PC_REG));
        b_br   = (unit_e'(b_unit) == U_BR) || (b_wr && b_dst == RW'(PC_REG));
        raw    = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (b_use[i] && a_wr && b_src[i] == a_dst) raw = 1'b1;
        end
        clash = (unit_e'(a_unit) == U_LS && unit_e'(b_unit) == U_LS)
              || (unit_e'(b_unit) == U_MUL)
              || (a_br && b_br)
              || (a_wr && b_wr && a_dst == b_dst)
              || raw || b_multi || !a_last;

        pipe0 = a_valid && a_ok;
        pipe1 = pipe0 && b_valid && b_ok && !clash;

        if (!pipe0)      consume = 2'd0;
        else if (pipe1)  consume = 2'd2;
        else if (a_last) consume = 2'd1;
        else             consume = 2'd0;
    end
endmodule

// File: rtl/pair_issue.sv
module pair_issue #(
    parameter int NREG   = 16,
    parameter int NSRC   = 3,
    parameter int ITW    = 3,
    parameter int L_ALU  = 1,
    parameter int L_LS   = 2,
    parameter int L_MUL  = 3,
    parameter int PC_REG = NREG - 1,
    localparam int RW    = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    a_valid,
    input  logic [1:0]              a_unit,
    input  logic [RW-1:0]           a_dst,
    input  logic                    a_wr,
    input  logic [NSRC-1:0][RW-1:0] a_src,
    input  logic [NSRC-1:0]         a_use,
    input  logic                    a_multi,
    input  logic [ITW-1:0]          a_rest,
    input  logic                    b_valid,
    input  logic [1:0]              b_unit,
    input  logic [RW-1:0]           b_dst,
    input  logic                    b_wr,
    input  logic [NSRC-1:0][RW-1:0] b_src,
    input  logic [NSRC-1:0]         b_use,
    input  logic                    b_multi,
    output logic                    pipe0,
    output logic                    pipe1,
    output logic [1:0]              consume
);
    logic [NREG-1:0] rdy;
    logic            a_ok, b_ok;

    pi_src_check #(.NREG(NREG), .NSRC(NSRC), .RW(RW)) u_chk_a (
        .ready(rdy), .src(a_src), .use_en(a_use), .ok(a_ok)
    );

    pi_src_check #(.NREG(NREG), .NSRC(NSRC), .RW(RW)) u_chk_b (
        .ready(rdy), .src(b_src), .use_en(b_use), .ok(b_ok)
    );

    pi_pair_rules #(.NSRC(NSRC), .RW(RW), .ITW(ITW), .PC_REG(PC_REG)) u_rules (
        .a_valid(a_valid), .a_ok(a_ok), .a_unit(a_unit), .a_dst(a_dst),
        .a_wr(a_wr), .a_multi(a_multi), .a_rest(a_rest),
        .b_valid(b_valid), .b_ok(b_ok), .b_unit(b_unit), .b_dst(b_dst),
        .b_wr(b_wr), .b_src(b_src), .b_use(b_use), .b_multi(b_multi),
        .pipe0(pipe0), .pipe1(pipe1), .consume(consume)
    );

    pi_scoreboard #(.NREG(NREG), .RW(RW), .L_ALU(L_ALU), .L_LS(L_LS), .L_MUL(L_MUL)) u_sb (
        .clk(clk), .rst_n(rst_n),
        .set0(pipe0 && a_wr), .dst0(a_dst), .unit0(a_unit),
        .set1(pipe1 && b_wr), .dst1(b_dst), .unit1(b_unit),
        .ready(rdy)
    );
endmodule

// File: rtl/pi_checks.sv
module pi_checks #(
    parameter int RW     = 4,
    parameter int ITW    = 3,
    parameter int PC_REG = 15
) (
    input logic           clk,
    input logic           rst_n,
    input logic           a_valid,
    input logic [1:0]     a_unit,
    input logic [RW-1:0]  a_dst,
    input logic           a_wr,
    input logic           a_multi,
    input logic [ITW-1:0] a_rest,
    input logic [1:0]     b_unit,
    input logic [RW-1:0]  b_dst,
    input logic           b_wr,
    input logic           pipe0,
    input logic           pipe1,
    input logic [1:0]     consume
);
    logic a_br, b_br;
    assign a_br = (a_unit == 2'd3) || (a_wr && a_dst == RW'(PC_REG));
    assign b_br = (b_unit == 2'd3) || (b_wr && b_dst == RW'(PC_REG));

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !a_valid |-> (!pipe0 && consume == 2'd0));
    p_pipe_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pipe1 |-> pipe0);
    p_one_ls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe1 && a_unit == 2'd1) |-> (b_unit != 2'd1));
    p_mul_young_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pipe1 |-> (b_unit != 2'd2));
    p_one_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe1 && a_br) |-> !b_br);
    p_same_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe1 && a_wr && b_wr) |-> (a_dst != b_dst));
    p_multi_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_multi && a_rest != '0) |-> (!pipe1 && consume == 2'd0));
    p_pair_consume_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pipe1 |-> (consume == 2'd2));
    p_none_consume_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe0 |-> (consume == 2'd0));
endmodule

bind pair_issue pi_checks #(.RW(RW), .ITW(ITW), .PC_REG(PC_REG)) u_checks (
    .clk(clk), .rst_n(rst_n), .a_valid(a_valid), .a_unit(a_unit),
    .a_dst(a_dst), .a_wr(a_wr), .a_multi(a_multi), .a_rest(a_rest),
    .b_unit(b_unit), .b_dst(b_dst), .b_wr(b_wr),
    .pipe0(pipe0), .pipe1(pipe1), .consume(consume)
);

// File: tb/pair_issue_test.sv
module pair_issue_test;
    localparam int NREG = 16;
    localparam int NSRC = 3;
    localparam int ITW  = 3;
    localparam int RW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_valid, a_wr, a_multi, b_valid, b_wr, b_multi;
    logic [1:0] a_unit, b_unit;
    logic [RW-1:0] a_dst, b_dst;
    logic [NSRC-1:0][RW-1:0] a_src, b_src;
    logic [NSRC-1:0] a_use, b_use;
    logic [ITW-1:0] a_rest;
    logic pipe0, pipe1;
    logic [1:0] consume;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pair_issue uut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_unit(a_unit), .a_dst(a_dst), .a_wr(a_wr),
        .a_src(a_src), .a_use(a_use), .a_multi(a_multi), .a_rest(a_rest),
        .b_valid(b_valid), .b_unit(b_unit), .b_dst(b_dst), .b_wr(b_wr),
        .b_src(b_src), .b_use(b_use), .b_multi(b_multi),
        .pipe0(pipe0), .pipe1(pipe1), .consume(consume)
    );

    typedef struct packed {
        logic [1:0]    au;
        logic [RW-1:0] ad;
        logic          aw;
        logic [1:0]    bu;
        logic [RW-1:0] bd;
        logic          bw;
        logic [RW-1:0] bs;
        logic          bsu;
        logic          e0;
        logic          e1;
        logic [1:0]    ec;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TAB [NV] = '{
        '{2'd1, 4'd5, 1'b1, 2'd1, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 2'd1},
        '{2'd1, 4'd5, 1'b1, 2'd0, 4'd9, 1'b1, 4'd0, 1'b0, 1'b1, 1'b1, 2'd2},
        '{2'd0, 4'd1, 1'b1, 2'd2, 4'd4, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0, 2'd1},
        '{2'd2, 4'd4, 1'b1, 2'd0, 4'd1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b1, 2'd2},
        '{2'd3, 4'd0, 1'b0, 2'd3, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 2'd1},
        '{2'd3, 4'd0, 1'b0, 2'd0, 4'd1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b1, 2'd2},
        '{2'd0, 4'd15, 1'b1, 2'd3, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 2'd1},
        '{2'd0, 4'd1, 1'b1, 2'd0, 4'd1, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0, 2'd1},
        '{2'd0, 4'd1, 1'b1, 2'd0, 4'd2, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0, 2'd1},
        '{2'd0, 4'd1, 1'b1, 2'd0, 4'd2, 1'b1, 4'd3, 1'b1, 1'b1, 1'b1, 2'd2}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4, 5, 6: return "R5";
            7:       return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic idle();
        a_valid = 0; a_unit = 0; a_dst = 0; a_wr = 0; a_src = '0; a_use = '0;
        a_multi = 0; a_rest = '0;
        b_valid = 0; b_unit = 0; b_dst = 0; b_wr = 0; b_src = '0; b_use = '0;
        b_multi = 0;
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {pipe0,pipe1,consume} actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idle();
        end
    endtask

    task automatic lat_run(input logic [1:0] unit, input int exp_stall, input string req);
        int n;
        logic bad;
        @(negedge clk);
        idle();
        a_valid = 1; a_unit = unit; a_dst = 4'd1; a_wr = 1;
        #1;
        check(req, {pipe0, pipe1, consume}, {1'b1, 1'b0, 2'd1});
        @(negedge clk);
        idle();
        a_valid = 1; a_unit = 0; a_dst = 4'd4; a_wr = 1; a_src[0] = 4'd1; a_use = 3'b001;
        b_valid = 1; b_unit = 0; b_dst = 4'd8; b_wr = 1;
        n = 0; bad = 0;
        for (int k = 0; k < 10; k++) begin
            #1;
            if (pipe1 && !pipe0) bad = 1;
            if (pipe0) break;
            n++;
            @(negedge clk);
        end
        checks++;
        if (n != exp_stall) begin
            errors++;
            $display("FAIL R9: stall actual %0d expected %0d", n, exp_stall);
        end
        checks++;
        if (bad || !pipe1) begin
            errors++;
            $display("FAIL R7: younger issue actual bad=%0b pipe1=%0b expected bad=0 pipe1=1",
                     bad, pipe1);
        end
        drain(4);
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check("R1", {pipe0, pipe1, consume}, 4'b0000);

        // R1: all sources in use and ready after reset
        @(negedge clk);
        a_valid = 1; a_unit = 0; a_dst = 4'd6; a_wr = 1;
        a_src = {4'd3, 4'd2, 4'd1}; a_use = 3'b111;
        #1;
        check("R1", {pipe0, pipe1, consume}, {1'b1, 1'b0, 2'd1});
        drain(4);

        // Pairing table: R2 R3 R4 R5 R6 R8 R11
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            a_valid = 1; a_unit = TAB[i].au; a_dst = TAB[i].ad; a_wr = TAB[i].aw;
            b_valid = 1; b_unit = TAB[i].bu; b_dst = TAB[i].bd; b_wr = TAB[i].bw;
            b_src[0] = TAB[i].bs; b_use[0] = TAB[i].bsu;
            #1;
            check($sformatf("%s/R2/R11 vector %0d", tag_of(i), i),
                  {pipe0, pipe1, consume}, {TAB[i].e0, TAB[i].e1, TAB[i].ec});
            drain(4);
        end

        // R9 latency per producer class, R7 blocking
        lat_run(2'd0, 1, "R9 alu");
        lat_run(2'd1, 2, "R9 ls");
        lat_run(2'd2, 3, "R9 mul");

        // R10: four-transfer multi-cycle load
        for (int r = 3; r >= 0; r--) begin
            @(negedge clk);
            idle();
            a_valid = 1; a_unit = 2'd1; a_dst = 4'd4; a_wr = 1; a_multi = 1;
            a_rest = ITW'(r);
            b_valid = 1; b_unit = 0; b_dst = 4'd8; b_wr = 1;
            #1;
            if (r != 0) check("R10 non-final", {pipe0, pipe1, consume}, {1'b1, 1'b0, 2'd0});
            else        check("R10 final", {pipe0, pipe1, consume}, {1'b1, 1'b1, 2'd2});
        end
        drain(4);

        // R10: younger multi-cycle never pairs
        @(negedge clk);
        a_valid = 1; a_unit = 0; a_dst = 4'd2; a_wr = 1;
        b_valid = 1; b_unit = 2'd1; b_dst = 4'd9; b_wr = 1; b_multi = 1;
        #1;
        check("R10 younger", {pipe0, pipe1, consume}, {1'b1, 1'b0, 2'd1});
        drain(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule